// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block keeps dynamic memory alive by issuing periodic CAS-before-RAS refresh cycles. A slow reference tick from the crystal clock, already brought into the bus clock domain as a one-cycle pulse, is divided by four and then by a programmable reload count, so that a refresh falls due every (count + 1) × 4 reference ticks. When one falls due the block raises a request to the bus cycle sequencer. It keeps that request up until the sequencer grants the bus, which the sequencer does only between accesses. A refresh that falls due during a bus cycle therefore waits for that cycle to end, and then goes ahead of any new access.

On a grant the block drives a refresh pulse on every bank marked as DRAM. CAS falls first and RAS follows one bus clock later. Both stay low, and both return high for a final precharge clock. The length of the whole cycle comes from a 2-bit code. The configuration field packs the 8-bit reload count, an enable bit and the length code. Any change to the count restarts the interval from zero. Expiries that occur while a request is already waiting merge into that single request.

Top module: `dram_rfsh_timer`

## Requirements
- R1: After reset, `refresh_req` and `refresh_busy` are 0 and every bit of `ras_n` and `cas_n` is 1.
- R2: With refresh enabled (`rfsh_cfg[2]` = 1), `refresh_req` rises on the clock edge that samples the (N+1)×4-th `ref_tick` since the last restart, where N = `rfsh_cfg[10:3]`. With ticks at a steady rate, consecutive rises are exactly (N+1)×4 tick periods apart.
- R3: While the enable bit is 0, no request is raised. Clearing the enable bit drops a pending request on the next edge.
- R4: The length code `rfsh_cfg[1:0]`, sampled at grant, sets how many bus clocks `refresh_busy` stays high: 00 gives 8, 01 gives 6, 10 gives 5 and 11 gives 4.
- R5: In a refresh, CAS is low from the first busy clock through the second-to-last. RAS is low from the second busy clock through the second-to-last. Both are high in the last busy clock. RAS is never low on a bank whose CAS is high.
- R6: A pending request stays high and no refresh pulse starts until `grant` is sampled high while the block is idle.
- R7: Only banks whose `dram_sel` bit is 1 at grant are pulsed. All other bits of `ras_n` and `cas_n` stay 1.
- R8: Any change of the count field restarts the interval, and the next expiry is timed from the new count.
- R9: Expiries that occur while a request is still pending are merged, so one grant yields exactly one refresh.
- R10: On the edge that accepts a grant, `refresh_req` falls and `refresh_busy` rises. A `grant` held high during a refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle pulse per reference (crystal) clock period |
| rfsh_cfg | input | 11 | [10:3] reload count, [2] enable, [1:0] length code |
| dram_sel | input | 5 | One bit per bank: 1 marks the bank as DRAM |
| grant | input | 1 | Bus granted by the cycle sequencer |
| refresh_req | output | 1 | Refresh request to the cycle sequencer |
| ras_n | output | 5 | Active-low RAS per bank |
| cas_n | output | 5 | Active-low CAS per bank |
| refresh_busy | output | 1 | High for every bus clock of a refresh cycle |

## Verification
The in-line assertions check the properties that hold on every clock. They confirm the CAS-before-RAS relation on each bank and that no unselected bank is pulsed. They confirm that an accepted grant always starts a busy cycle, that the phase counter stays inside the programmed length, and that a disabled block holds no request. Some behaviour is only visible across whole scenarios, so the bench has to show it: the exact interval in reference ticks, the restart on a new count, the merging of several expiries into one refresh, and the per-code pulse lengths. The bench covers these with a behavioural model compared on every clock and with directed measurements.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    LEN_8 = 2'b00,
    LEN_6 = 2'b01,
    LEN_5 = 2'b10,
    LEN_4 = 2'b11
  } rfsh_len_e;

  // Refresh cycle length in bus clocks for a given code.
  function automatic logic [3:0] rfsh_len(input logic [1:0] code);
    case (rfsh_len_e'(code))
      LEN_8:   rfsh_len = 4'd8;
      LEN_6:   rfsh_len = 4'd6;
      LEN_5:   rfsh_len = 4'd5;
      default: rfsh_len = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             due_o
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] ivl_q;
  logic             restart;
  logic             wrap;

  assign restart = (count_i != cnt_q) | (en_i & ~en_q);
  assign wrap    = tick_i & (pre_q == PRE_LAST);
  assign due_o   = en_i & ~restart & wrap & (ivl_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      pre_q <= '0;
      ivl_q <= '0;
    end else begin
      cnt_q <= count_i;
      en_q  <= en_i;
      if (restart || !en_i) begin
        pre_q <= '0;
        ivl_q <= count_i;
      end else if (tick_i) begin
        if (wrap) begin
          pre_q <= '0;
          ivl_q <= (ivl_q == '0) ? count_i : ivl_q - CNT_W'(1);
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

  // R2
  ivl_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (ivl_q <= cnt_q));

  // R8
  restart_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && count_i != cnt_q) |=> (ivl_q == $past(count_i) && pre_q == '0));

endmodule

// File: rtl/rfsh_req_arbiter.sv
module rfsh_req_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic due_i,
  input  logic grant_i,
  input  logic seq_idle_i,
  output logic req_o,
  output logic start_o
);
  logic req_q;

  assign start_o = req_q & grant_i & seq_idle_i;
  assign req_o   = req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= en_i & (due_i | (req_q & ~start_o));
  end

  // R3
  no_req_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !req_o);

  // R9
  single_service_chk: assert property (@(posedge clk) disable iff (rst)
    (start_o && !due_i) |=> !req_o);

  // R6
  hold_until_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && en_i && !start_o) |=> req_o);

endmodule

// File: rtl/rfsh_pulse_seq.sv
module rfsh_pulse_seq
  import dram_rfsh_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int LEN_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [1:0]           len_code_i,
  input  logic [NUM_BANKS-1:0] bank_sel_i,
  output logic                 idle_o,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_BANKS-1:0] cas_n_o
);
  logic                 active_q;
  logic [LEN_W-1:0]     k_q;
  logic [LEN_W-1:0]     len_q;
  logic [NUM_BANKS-1:0] mask_q;
  logic                 busy_q;

  logic                 nxt_active;
  logic [LEN_W-1:0]     nxt_k;
  logic [LEN_W-1:0]     len_now;
  logic [NUM_BANKS-1:0] mask_now;
  logic                 cas_on;
  logic                 ras_on;

  always_comb begin
    len_now    = start_i ? LEN_W'(rfsh_len(len_code_i)) : len_q;
    mask_now   = start_i ? bank_sel_i : mask_q;
    nxt_active = active_q;
    nxt_k      = k_q;
    if (start_i) begin
      nxt_active = 1'b1;
      nxt_k      = '0;
    end else if (active_q) begin
      if (k_q == len_q - LEN_W'(1)) begin
        nxt_active = 1'b0;
        nxt_k      = '0;
      end else begin
        nxt_k = k_q + LEN_W'(1);
      end
    end
    cas_on = nxt_active && (nxt_k <= len_now - LEN_W'(2));
    ras_on = nxt_active && (nxt_k != '0) && (nxt_k <= len_now - LEN_W'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      k_q      <= '0;
      len_q    <= LEN_W'(8);
      mask_q   <= '0;
      busy_q   <= 1'b0;
    end else begin
      active_q <= nxt_active;
      k_q      <= nxt_k;
      len_q    <= len_now;
      mask_q   <= mask_now;
      busy_q   <= nxt_active;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic ras_r;
    logic cas_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        ras_r <= 1'b1;
        cas_r <= 1'b1;
      end else begin
        ras_r <= ~(ras_on & mask_now[b]);
        cas_r <= ~(cas_on & mask_now[b]);
      end
    end
    assign ras_n_o[b] = ras_r;
    assign cas_n_o[b] = cas_r;
  end

  assign idle_o = ~active_q;
  assign busy_o = busy_q;

  // R5
  cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
    ((~ras_n_o) & cas_n_o) == '0);

  // R5
  ras_high_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (&ras_n_o));

  // R7
  bank_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (((~cas_n_o) | (~ras_n_o)) & ~mask_q) == '0);

  // R10
  grant_starts_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (k_q < len_q));

endmodule

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer
  import dram_rfsh_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int CNT_W     = 8,
  parameter int PRESCALE  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_tick,
  input  logic [CNT_W+2:0]       rfsh_cfg,
  input  logic [NUM_BANKS-1:0]   dram_sel,
  input  logic                   grant,
  output logic                   refresh_req,
  output logic [NUM_BANKS-1:0]   ras_n,
  output logic [NUM_BANKS-1:0]   cas_n,
  output logic                   refresh_busy
);
  localparam int CFG_W   = CNT_W + 3;
  localparam int EN_BIT  = 2;
  localparam int CNT_LSB = 3;

  logic [CNT_W-1:0] cfg_count;
  logic             cfg_en;
  logic [1:0]       cfg_len;
  logic             due;
  logic             start;
  logic             seq_idle;

  assign cfg_count = rfsh_cfg[CFG_W-1:CNT_LSB];
  assign cfg_en    = rfsh_cfg[EN_BIT];
  assign cfg_len   = rfsh_cfg[1:0];

  rfsh_interval_timer #(
    .CNT_W   (CNT_W),
    .PRESCALE(PRESCALE)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (ref_tick),
    .en_i   (cfg_en),
    .count_i(cfg_count),
    .due_o  (due)
  );

  rfsh_req_arbiter arb_i (
    .clk       (clk),
    .rst       (rst),
    .en_i      (cfg_en),
    .due_i     (due),
    .grant_i   (grant),
    .seq_idle_i(seq_idle),
    .req_o     (refresh_req),
    .start_o   (start)
  );

  rfsh_pulse_seq #(
    .NUM_BANKS(NUM_BANKS),
    .LEN_W    (4)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .len_code_i(cfg_len),
    .bank_sel_i(dram_sel),
    .idle_o    (seq_idle),
    .busy_o    (refresh_busy),
    .ras_n_o   (ras_n),
    .cas_n_o   (cas_n)
  );

  // R10
  req_drops_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && grant && !refresh_busy && seq_idle && !due) |=> (!refresh_req && refresh_busy));

endmodule

// File: tb/dram_rfsh_timer_tb_top.sv
module dram_rfsh_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 5;
  localparam int TICK_DIV   = 3;
  localparam int WDOG       = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick = 1'b0;
  logic [10:0]   rfsh_cfg = '0;
  logic [NB-1:0] dram_sel = '0;
  logic          grant = 1'b0;
  logic          refresh_req;
  logic [NB-1:0] ras_n;
  logic [NB-1:0] cas_n;
  logic          refresh_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rfsh_timer #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .rfsh_cfg(rfsh_cfg),
    .dram_sel(dram_sel), .grant(grant), .refresh_req(refresh_req),
    .ras_n(ras_n), .cas_n(cas_n), .refresh_busy(refresh_busy));

  int n_checks = 0;
  int n_fails  = 0;
  string tag = "R1";
  int gmode = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      0: return 8;
      1: return 6;
      2: return 5;
      default: return 4;
    endcase
  endfunction

  function automatic logic [10:0] cfg(input int cnt, input bit en, input int code);
    return {cnt[7:0], en, code[1:0]};
  endfunction

  // Behavioural reference model
  int m_ticks, m_seq, m_len, m_cnt_prev;
  bit m_pend, m_en_prev;
  logic [NB-1:0] m_mask;

  always @(posedge clk) begin
    int cnt, code;
    bit en, restart, due, start;
    if (rst) begin
      m_ticks = 0; m_seq = -1; m_len = 8; m_cnt_prev = 0;
      m_pend = 0; m_en_prev = 0; m_mask = '0;
    end else begin
      cnt = int'(rfsh_cfg[10:3]); en = rfsh_cfg[2]; code = int'(rfsh_cfg[1:0]);
      restart = (cnt != m_cnt_prev) || (en && !m_en_prev);
      due = 0;
      if (restart || !en) m_ticks = 0;
      else if (ref_tick) begin
        m_ticks++;
        if (m_ticks == (cnt + 1) * 4) begin due = 1; m_ticks = 0; end
      end
      start = m_pend && grant && (m_seq < 0);
      m_pend = en && (due || (m_pend && !start));
      if (start) begin m_seq = 0; m_len = len_of(code); m_mask = dram_sel; end
      else if (m_seq >= 0) m_seq = (m_seq == m_len - 1) ? -1 : m_seq + 1;
      m_cnt_prev = cnt; m_en_prev = en;
    end
  end

  always @(negedge clk) begin
    logic [NB-1:0] ec, er;
    bit eb;
    if (!rst) begin
      eb = (m_seq >= 0);
      for (int b = 0; b < NB; b++) begin
        ec[b] = !(eb && m_mask[b] && m_seq <= m_len - 2);
        er[b] = !(eb && m_mask[b] && m_seq >= 1 && m_seq <= m_len - 2);
      end
      check({refresh_req, refresh_busy, ras_n, cas_n} == {m_pend, eb, er, ec}, tag,
            int'({refresh_req, refresh_busy, ras_n, cas_n}), int'({m_pend, eb, er, ec}));
    end
  end

  // Monitor
  int cyc = 0, busy_rises = 0, req_rises = 0, last_req_rise = 0;
  bit prev_busy = 0, prev_req = 0;
  always @(negedge clk) begin
    cyc++;
    if (refresh_busy && !prev_busy) busy_rises++;
    if (refresh_req && !prev_req) begin req_rises++; last_req_rise = cyc; end
    prev_busy = refresh_busy; prev_req = refresh_req;
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_req_rise();
    int r0 = req_rises;
    while (req_rises == r0) step();
  endtask

  task automatic measure_cycle(input int code);
    int blen = 0, cas_first = -1, ras_first = -1;
    bit last_high = 0;
    rfsh_cfg = cfg(0, 1, code);
    gmode = 1;
    while (!refresh_busy) step();
    // R10: request drops on the edge that raises busy
    check(refresh_req == 1'b0, "R10", refresh_req, 0);
    check(cas_n == ~dram_sel, "R7", cas_n, int'(~dram_sel));
    while (refresh_busy) begin
      if (cas_first < 0 && cas_n != '1) cas_first = blen;
      if (ras_first < 0 && ras_n != '1) ras_first = blen;
      last_high = (ras_n == '1) && (cas_n == '1);
      blen++;
      step();
    end
    check(blen == len_of(code), "R4", blen, len_of(code));
    check(cas_first == 0, "R5", cas_first, 0);
    check(ras_first == 1, "R5", ras_first, 1);
    check(last_high, "R5", last_high, 1);
    gmode = 0;
    step(2);
  endtask

  initial begin
    fork
      begin : ticker
        int t = 0;
        forever begin @(negedge clk); t++; ref_tick = (t % TICK_DIV) == 0; end
      end
      begin : granter
        int g = 0;
        forever begin
          @(negedge clk);
          case (gmode)
            0: grant = 1'b0;
            1: grant = 1'b1;
            default: begin g = refresh_req ? g + 1 : 0; grant = (g >= 3); end
          endcase
        end
      end
    join_none

    fork
      begin : main
        int t1, r0, b0;
        dram_sel = 5'b00101;
        step(4);
        rst = 1'b0;
        step();
        tag = "R1";
        check(refresh_req == 0 && refresh_busy == 0, "R1", {refresh_req, refresh_busy}, 0);
        check(ras_n == '1 && cas_n == '1, "R1", {ras_n, cas_n}, 10'h3FF);

        // R2: interval of (N+1)*4 ticks
        tag = "R2";
        gmode = 2;
        rfsh_cfg = cfg(2, 1, 3);
        wait_req_rise();
        t1 = last_req_rise;
        wait_req_rise();
        check(last_req_rise - t1 == 3 * 4 * TICK_DIV, "R2", last_req_rise - t1, 3 * 4 * TICK_DIV);
        gmode = 0;
        step(10);

        // R4 R5 R7 R10: every length code, different bank patterns, grant held
        tag = "R4";
        dram_sel = 5'b10010;
        measure_cycle(0);
        dram_sel = 5'b01111;
        measure_cycle(1);
        dram_sel = 5'b11111;
        measure_cycle(2);
        dram_sel = 5'b00001;
        measure_cycle(3);

        // R6 R9: no grant across several expiries, then one refresh
        tag = "R6";
        gmode = 0;
        rfsh_cfg = cfg(3, 1, 0);
        b0 = busy_rises;
        step(200);
        check(refresh_req == 1, "R6", refresh_req, 1);
        check(busy_rises == b0, "R6", busy_rises - b0, 0);
        tag = "R9";
        gmode = 2;
        step(20);
        check(busy_rises == b0 + 1, "R9", busy_rises - b0, 1);
        check(refresh_req == 0, "R9", refresh_req, 0);
        gmode = 0;
        step(30);

        // R3: disable drops a pending request and blocks new ones
        tag = "R3";
        rfsh_cfg = cfg(0, 1, 3);
        step(30);
        check(refresh_req == 1, "R3", refresh_req, 1);
        rfsh_cfg = cfg(0, 0, 3);
        step();
        check(refresh_req == 0, "R3", refresh_req, 0);
        gmode = 2;
        r0 = req_rises;
        step(150);
        check(req_rises == r0, "R3", req_rises - r0, 0);

        // R8: new count restarts the interval
        tag = "R8";
        rfsh_cfg = cfg(10, 1, 3);
        step(60);
        r0 = req_rises;
        rfsh_cfg = cfg(1, 1, 3);
        t1 = cyc;
        wait_req_rise();
        check(req_rises == r0 + 1, "R8", req_rises - r0, 1);
        check(last_req_rise - t1 >= 20 && last_req_rise - t1 <= 28, "R8", last_req_rise - t1, 24);
        step(40);

        // R1: reset in mid-operation returns to idle
        tag = "R1";
        rst = 1'b1;
        step(2);
        check(refresh_req == 0 && refresh_busy == 0 && ras_n == '1 && cas_n == '1, "R1",
              {refresh_req, refresh_busy, ras_n, cas_n}, 12'h3FF);
        rst = 1'b0;
        step(5);
      end
      begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R6 watchdog: actual=%0d expected=completion", WDOG);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule